// File: doc/BRIEF.md
# Parallel Flash Command Buffer Executor

This block replays a prepared list of flash operations held in a byte-wide buffer RAM. After a one-cycle `start` strobe it reads the buffer from byte zero up to the fill pointer. Each entry announces its own kind and length. A write entry turns into a burst of parallel-flash write cycles at consecutive addresses. A delay entry makes the block wait a number of microseconds before it parses the next entry.

The buffer is read through a synchronous single-port RAM port. `buf_rd_en` and `buf_addr` are presented in one cycle, and the byte comes back on `buf_rdata` in the next cycle. The read latency is fixed, so no valid/ready pair exists and no back-pressure applies. The block never holds more than one read outstanding.

The flash side is a plain address, data, chip-enable and write-enable bus. When the walk ends, `done` pulses for one cycle. `err` then tells whether the walk ended cleanly or was aborted.

Top module: `flash_cmd_runner`

## Requirements
- R1: A write entry is the byte 0x01, a length byte, a 24-bit start address in three bytes with the most significant byte first, and then that many data bytes. Each data byte produces exactly one flash write cycle that carries that byte.
- R2: The data bytes of one write entry go to consecutive flash addresses, starting at the entry address. The address wraps from 0xFFFFFF to 0x000000.
- R3: A length byte of 0x00 stands for 256 data bytes.
- R4: A delay entry is the byte 0x02 followed by a 16-bit count, most significant byte first. The next entry is not parsed until at least count × CLKS_PER_US clocks have passed. The total run time exceeds that figure by no more than 16 clocks. A count of zero adds no wait.
- R5: In every flash write cycle, address and data are valid, with chip-enable low and write-enable high, for at least one clock before write-enable falls. Write-enable then stays low for exactly WE_LOW_CLKS clocks, with address and data stable, and rises before the address changes.
- R6: An opcode byte other than 0x01 or 0x02 stops the walk. It sets `err`, pulses `done`, and causes no further flash write.
- R7: If the fill pointer is reached in the middle of an entry, the walk stops with `err` set and `done` pulsed. Data bytes already read are still written.
- R8: When the fill pointer is reached at an entry boundary, `done` pulses for exactly one clock with `err` low. An empty buffer (fill pointer 0) gives `done` with no flash write.
- R9: A `start` strobe while `busy` is high is ignored. A new `start` clears `err`.
- R10: After reset, `flash_ce_n` and `flash_we_n` are high, and `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a walk |
| fill_ptr | input | BUF_AW+1 | Number of valid bytes in the buffer |
| buf_rd_en | output | 1 | Buffer RAM read enable |
| buf_addr | output | BUF_AW | Buffer RAM byte address |
| buf_rdata | input | 8 | Buffer RAM read data, one cycle after `buf_rd_en` |
| flash_addr | output | 24 | Flash address |
| flash_dq | output | 8 | Flash write data |
| flash_ce_n | output | 1 | Flash chip-enable, active low |
| flash_we_n | output | 1 | Flash write-enable, active low |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| err | output | 1 | Walk aborted; held until the next start |

## Verification
The bench aims at the zero-length code. A design that read it as zero would write nothing, or 255 bytes, and the write log would come out short. It also sends a write entry across the top of the 24-bit space. A design that got this wrong would carry into nothing, or stop, instead of wrapping to address zero. Abort paths are covered by a bad opcode placed after a good entry and by a fill pointer that cuts an entry short; a design that mishandled either would keep writing or finish without `err`. Delay entries are timed against the expected clock count, so a prescaler that is off by one, or a zero count that hangs, both show up.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h01;
  localparam logic [7:0] OPC_DELAY = 8'h02;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_WRITE, S_DELAY
  } run_state_t;

  typedef enum logic [2:0] {
    PH_OPC, PH_LEN, PH_A2, PH_A1, PH_A0, PH_DATA, PH_DHI, PH_DLO
  } field_t;
endpackage

// File: rtl/fcr_byte_fetch.sv
module fcr_byte_fetch #(
  parameter int BUF_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BUF_AW-1:0] ptr,
  output logic              mem_rd_en,
  output logic [BUF_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              byte_vld,
  output logic [7:0]        byte_out
);
  assign mem_rd_en = req;
  assign mem_addr  = ptr;
  assign byte_out  = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_vld <= 1'b0;
    else        byte_vld <= req;
  end

  // only one read in flight: a byte never arrives in the cycle a new read is issued
  p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
endmodule

// File: rtl/fcr_us_timer.sv
module fcr_us_timer #(
  parameter int CLKS_PER_US = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] count,
  output logic        done
);
  localparam int PW = $clog2(CLKS_PER_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

  logic          run;
  logic [PW-1:0] pre;
  logic [15:0]   rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pre  <= '0;
      rem  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        pre <= '0;
        rem <= count;
      end else if (run) begin
        if (rem == 16'd0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else if (pre == PRE_LAST) begin
          pre <= '0;
          rem <= rem - 16'd1;
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end

  p_prescale_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_LAST);
  p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));
endmodule

// File: rtl/fcr_wr_strobe.sv
module fcr_wr_strobe #(
  parameter int WE_LOW_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] addr_in,
  input  logic [7:0]  data_in,
  output logic [23:0] flash_addr,
  output logic [7:0]  flash_dq,
  output logic        flash_ce_n,
  output logic        flash_we_n,
  output logic        done
);
  localparam int CW = $clog2(WE_LOW_CLKS + 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(WE_LOW_CLKS - 1);

  typedef enum logic [1:0] {W_IDLE, W_SETUP, W_LOW, W_HOLD} wst_t;
  wst_t          st;
  logic [CW-1:0] cnt;

  assign done = (st == W_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      cnt        <= '0;
      flash_addr <= '0;
      flash_dq   <= '0;
      flash_ce_n <= 1'b1;
      flash_we_n <= 1'b1;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          flash_addr <= addr_in;
          flash_dq   <= data_in;
          flash_ce_n <= 1'b0;
          st         <= W_SETUP;
        end
        W_SETUP: begin
          flash_we_n <= 1'b0;
          cnt        <= '0;
          st         <= W_LOW;
        end
        W_LOW: begin
          if (cnt == LOW_LAST) begin
            flash_we_n <= 1'b1;
            st         <= W_HOLD;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          flash_ce_n <= 1'b1;
          st         <= W_IDLE;
        end
      endcase
    end
  end

  p_setup_before_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> $stable(flash_addr) && $stable(flash_dq) && !flash_ce_n);
  p_stable_while_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> $stable(flash_addr) && $stable(flash_dq));
  p_ce_covers_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> !flash_ce_n);
  p_no_addr_change_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(flash_addr) |-> flash_we_n && $past(flash_we_n));
endmodule

// File: rtl/flash_cmd_runner.sv
module flash_cmd_runner
  import fcr_pkg::*;
#(
  parameter int BUF_AW      = 10,
  parameter int CLKS_PER_US = 125,
  parameter int WE_LOW_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUF_AW:0]   fill_ptr,
  output logic              buf_rd_en,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic [23:0]       flash_addr,
  output logic [7:0]        flash_dq,
  output logic              flash_ce_n,
  output logic              flash_we_n,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int PW = BUF_AW + 1;

  run_state_t  state;
  field_t      field;
  logic [PW-1:0] ptr;
  logic [8:0]  rem;
  logic [23:0] waddr;
  logic [7:0]  dly_hi;

  logic       fetch_req;
  logic       byte_vld;
  logic [7:0] byte_in;
  logic       wr_go, wr_done;
  logic       tm_go, tm_done;
  logic [15:0] tm_count;

  assign fetch_req = (state == S_FETCH) && (ptr != fill_ptr);
  assign wr_go     = (state == S_WAIT) && (field == PH_DATA);
  assign tm_go     = (state == S_WAIT) && (field == PH_DLO);
  assign tm_count  = {dly_hi, byte_in};
  assign busy      = (state != S_IDLE);

  fcr_byte_fetch #(.BUF_AW(BUF_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .req(fetch_req), .ptr(ptr[BUF_AW-1:0]),
    .mem_rd_en(buf_rd_en), .mem_addr(buf_addr), .mem_rdata(buf_rdata),
    .byte_vld(byte_vld), .byte_out(byte_in)
  );

  fcr_wr_strobe #(.WE_LOW_CLKS(WE_LOW_CLKS)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .addr_in(waddr), .data_in(byte_in),
    .flash_addr(flash_addr), .flash_dq(flash_dq), .flash_ce_n(flash_ce_n),
    .flash_we_n(flash_we_n), .done(wr_done)
  );

  fcr_us_timer #(.CLKS_PER_US(CLKS_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tm_go), .count(tm_count), .done(tm_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      field  <= PH_OPC;
      ptr    <= '0;
      rem    <= '0;
      waddr  <= '0;
      dly_hi <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_FETCH;
          field <= PH_OPC;
          ptr   <= '0;
          err   <= 1'b0;
        end
        S_FETCH: begin
          if (ptr == fill_ptr) begin
            done  <= 1'b1;
            err   <= (field != PH_OPC);
            state <= S_IDLE;
          end else begin
            ptr   <= ptr + PW'(1);
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          state <= S_FETCH;
          case (field)
            PH_OPC: begin
              if (byte_in == OPC_WRITE)      field <= PH_LEN;
              else if (byte_in == OPC_DELAY) field <= PH_DHI;
              else begin
                err   <= 1'b1;
                done  <= 1'b1;
                state <= S_IDLE;
              end
            end
            PH_LEN: begin
              rem   <= (byte_in == 8'd0) ? 9'd256 : {1'b0, byte_in};
              field <= PH_A2;
            end
            PH_A2: begin waddr[23:16] <= byte_in; field <= PH_A1; end
            PH_A1: begin waddr[15:8]  <= byte_in; field <= PH_A0; end
            PH_A0: begin waddr[7:0]   <= byte_in; field <= PH_DATA; end
            PH_DATA: state <= S_WRITE;
            PH_DHI: begin dly_hi <= byte_in; field <= PH_DLO; end
            default: state <= S_DELAY;
          endcase
        end
        S_WRITE: if (wr_done) begin
          waddr <= waddr + 24'd1;
          rem   <= rem - 9'd1;
          field <= (rem == 9'd1) ? PH_OPC : PH_DATA;
          state <= S_FETCH;
        end
        default: if (tm_done) begin
          field <= PH_OPC;
          state <= S_FETCH;
        end
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  p_byte_ready_in_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> byte_vld);
  p_idle_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> flash_we_n);
  p_ignore_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_FETCH) |=> ptr != '0 || state == S_IDLE);
endmodule

// File: tb/flash_cmd_runner_test.sv
module flash_cmd_runner_test;
  localparam int AW  = 10;
  localparam int DIV = 5;
  localparam int WEL = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW:0] fill_ptr = '0;
  logic buf_rd_en;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_rdata;
  logic [23:0] flash_addr;
  logic [7:0] flash_dq;
  logic flash_ce_n, flash_we_n, busy, done, err;

  always #4 clk = ~clk;

  flash_cmd_runner #(.BUF_AW(AW), .CLKS_PER_US(DIV), .WE_LOW_CLKS(WEL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fill_ptr(fill_ptr),
    .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .flash_addr(flash_addr), .flash_dq(flash_dq), .flash_ce_n(flash_ce_n),
    .flash_we_n(flash_we_n), .busy(busy), .done(done), .err(err)
  );

  logic [7:0] mem [0:(1<<AW)-1];
  always_ff @(posedge clk) if (buf_rd_en) buf_rdata <= mem[buf_addr];

  int checks = 0, fails = 0;
  int wlen = 0;
  logic [23:0] exp_a [0:4095];
  logic [7:0]  exp_d [0:4095];
  int exp_n = 0;
  logic [23:0] log_a [0:4095];
  logic [7:0]  log_d [0:4095];
  int log_n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash bus monitor: cycle shape (R5) and write log
  logic pwe = 1'b1, pce = 1'b1;
  logic [23:0] pa = '0;
  logic [7:0]  pd = '0;
  int lowc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwe && !flash_we_n) begin
        chk(flash_addr == pa && flash_dq == pd && !pce, "R5 setup", flash_addr, pa);
        lowc = 1;
      end else if (!pwe && !flash_we_n) begin
        chk(flash_addr == pa && flash_dq == pd, "R5 hold", flash_addr, pa);
        lowc++;
      end else if (!pwe && flash_we_n) begin
        chk(lowc == WEL, "R5 low width", lowc, WEL);
        log_a[log_n] = pa; log_d[log_n] = pd; log_n++;
      end
    end
    pwe = flash_we_n; pce = flash_ce_n; pa = flash_addr; pd = flash_dq;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 37 + salt * 11 + 5) ^ (i >> 3));
  endfunction

  task automatic put(input logic [7:0] b);
    mem[wlen] = b; wlen++;
  endtask

  task automatic add_write(input logic [23:0] a, input int n, input int salt);
    put(8'h01); put(8'(n)); put(a[23:16]); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < (n == 0 ? 256 : n); i++) begin
      put(pat(i, salt));
      exp_a[exp_n] = a + 24'(i); exp_d[exp_n] = pat(i, salt); exp_n++;
    end
  endtask

  task automatic add_delay(input logic [15:0] n);
    put(8'h02); put(n[15:8]); put(n[7:0]);
  endtask

  task automatic clear_buf();
    wlen = 0; exp_n = 0;
  endtask

  task automatic run(output int cyc);
    log_n = 0;
    fill_ptr = (AW+1)'(wlen);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done, "R8 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic cmp_log(input string req);
    chk(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], req, log_a[i], exp_a[i]);
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(flash_ce_n && flash_we_n && !done && !err && !busy, "R10 reset",
        {flash_ce_n, flash_we_n, done, err, busy}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 empty buffer
    clear_buf(); run(cyc);
    chk(log_n == 0 && !err, "R8 empty", log_n, 0);

    // R1 R2 wrap across top of address space
    clear_buf(); add_write(24'hFFFFFE, 4, 1); run(cyc);
    cmp_log("R2 wrap"); chk(!err, "R1 no err", err, 0);

    // R3 length code zero
    clear_buf(); add_write(24'h012300, 0, 2); run(cyc);
    cmp_log("R3 len256");

    // R4 delay timing
    clear_buf(); add_delay(16'd40); run(cyc);
    chk(cyc >= 40*DIV && cyc <= 40*DIV + 16, "R4 delay 40", cyc, 40*DIV);
    clear_buf(); add_delay(16'd0); run(cyc);
    chk(cyc <= 16, "R4 delay 0", cyc, 16);
    clear_buf(); add_write(24'h000100, 2, 3); add_delay(16'd100); add_write(24'h000200, 1, 4);
    run(cyc); cmp_log("R4 writes around delay");
    chk(cyc >= 100*DIV && !err, "R4 delay between writes", cyc, 100*DIV);

    // R6 unknown opcode
    clear_buf(); add_write(24'h00AA00, 3, 5); put(8'h7E); put(8'h01); put(8'h02);
    run(cyc); cmp_log("R6 stop after bad opcode");
    chk(err, "R6 err set", err, 1);

    // R9 new start clears err
    clear_buf(); add_write(24'h000010, 1, 6); run(cyc);
    chk(!err, "R9 err cleared", err, 1'b0);

    // R7 truncated entry
    clear_buf(); add_write(24'h004000, 5, 7);
    wlen = wlen - 3; exp_n = 2;
    run(cyc); cmp_log("R7 partial writes");
    chk(err, "R7 err set", err, 1);

    // R9 start while busy ignored
    clear_buf(); add_write(24'h020000, 20, 8);
    fork
      run(cyc);
      begin repeat (40) @(negedge clk); start = 1'b1; @(negedge clk) start = 1'b0; end
    join
    cmp_log("R9 no restart");
    repeat (5) @(negedge clk);
    chk(!busy, "R9 idle after run", busy, 0);

    // random mixed buffers: R1 R2 R4
    for (int t = 0; t < 20; t++) begin
      clear_buf();
      while (wlen < 600) begin
        int k = $urandom_range(0, 9);
        if (k < 2) add_delay(16'($urandom_range(0, 3)));
        else if (k == 2) add_write(24'($urandom), 0, t);
        else add_write(24'($urandom), $urandom_range(1, 24), t + k);
      end
      run(cyc);
      cmp_log("R1 random");
      chk(!err, "R1 random err", err, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule